// File: doc/BRIEF.md
# Write-Once Byte Register Controller

This block guards a small array of one-time-programmable bytes, modelled as registers. A requester drives a single synchronous port with an address, write data, a write enable and a read enable. Each write is either accepted or refused, and the decision follows write-once rules. A byte can be programmed once only. After a byte holds any set bit, or after any write to it has been accepted, every later write to that byte is refused and the stored value does not change.

One extra address, just above the byte array, holds a lock flag. The lock flag is also write-once. When it is set, the whole array refuses every write until reset. The two highest bytes hold an identification code and a revision code. Both load at reset and count as already programmed. A refused write produces a one-cycle error pulse. Reads are always allowed and return data one cycle after the request.

Top module: `otp_once_regs`

## Requirements
- R1: After reset, bytes 0 to 29 read 0x00. Byte 31 reads {MAJOR_ID, MINOR_ID}, which is 0x91 by default. Byte 30 reads REV_ID, which is 0x23 by default. Address 32 (the lock flag) reads 0x00, and wrErr is low.
- R2: A read captures the addressed value at the clock edge that samples reqRe, and rdData shows it after that edge. rdData holds its value while reqRe is low. Reads are honoured whether or not the array is locked.
- R3: While unlocked, a write to a byte in range 0 to 29 that has never been written is accepted. wrErr stays low, and the byte holds the new data from the next edge onward.
- R4: A write to a byte in range 0 to 29 that was written before is refused with a wrErr pulse, and the byte keeps its value. This applies even when the earlier accepted data was 0x00.
- R5: While unlocked, bytes that have not been written stay writable after other bytes have been programmed.
- R6: Writes to address 30 or 31 are always refused with a wrErr pulse, and both bytes keep their reset values.
- R7: A write to address 32 with bit 0 high sets the lock flag and is accepted. A write to address 32 with bit 0 low, while unlocked, is accepted and changes nothing. A read of address 32 returns the lock flag in bit 0, with zeros above it.
- R8: While the lock flag is set, every write to any address is refused with a wrErr pulse and changes no state. Only reset clears the lock flag.
- R9: Writes to addresses 33 to 63 are refused with a wrErr pulse. Reads of those addresses return 0x00.
- R10: wrErr rises for exactly one cycle, in the cycle after each refused write. It is low after accepted writes and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqAddr | input | 6 | Byte address 0..31, lock flag at 32 |
| reqWdata | input | 8 | Write data |
| reqWe | input | 1 | Write request |
| reqRe | input | 1 | Read request |
| rdData | output | 8 | Registered read data |
| wrErr | output | 1 | One-cycle pulse for a refused write |

## Verification
Writes are tried in several patterns:
- Fresh bytes with nonzero data and with all-zero data. The zero-data case shows that the per-byte written flag is tracked, and not only the set bits.
- A second write to a byte already written, which separates acceptance from refusal.
- Writes to the identifier bytes and to out-of-range addresses.
- Writes to other fresh bytes after some bytes are programmed. This shows that refusal is per byte and not global.

The lock address is written first with bit 0 low and then with bit 0 high. Both writes are followed by writes and reads on the locked array, then by a second reset. Together these show that the flag is sticky, that it blocks all writes, and that reads still work while it is set.

// File: rtl/otp_once_pkg.sv
package otp_once_pkg;
  // Strobes from the decision logic to the storage
  typedef struct packed {
    logic wrByte;   // commit reqWdata to the addressed byte
    logic setLock;  // program the lock flag
    logic refuse;   // write refused, raise error next cycle
  } otpStrobes_t;
endpackage

// File: rtl/otp_once_ctrl.sv
module otp_once_ctrl
  import otp_once_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int ID_BYTES  = 2,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              lockBit,
  input  logic              reqWe,
  input  logic              tgtWritten,
  input  logic              lockState,
  output otpStrobes_t       strobes,
  output logic              wrErr
);
  localparam int ID_BASE = NUM_BYTES - ID_BYTES;
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(NUM_BYTES);
  localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_BASE);

  logic inArray, isId, isLock;

  assign isLock  = (reqAddr == LOCK_A);
  assign inArray = (reqAddr < LOCK_A);
  assign isId    = inArray && (reqAddr >= ID_A);

  always_comb begin
    strobes = '0;
    if (reqWe) begin
      if (lockState) begin
        strobes.refuse = 1'b1;
      end else if (isLock) begin
        strobes.setLock = lockBit;
      end else if (inArray && !isId && !tgtWritten) begin
        strobes.wrByte = 1'b1;
      end else begin
        strobes.refuse = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrErr <= 1'b0;
    else       wrErr <= strobes.refuse;
  end
endmodule

// File: rtl/otp_once_dp.sv
module otp_once_dp
  import otp_once_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int ID_BYTES  = 2,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter logic [3:0] MAJOR_ID = 4'h9,
  parameter logic [3:0] MINOR_ID = 4'h1,
  parameter logic [DATA_W-1:0] REV_ID = 8'h23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqRe,
  input  otpStrobes_t       strobes,
  output logic [DATA_W-1:0] rdData,
  output logic              tgtWritten,
  output logic              lockState
);
  localparam int IDX_W   = $clog2(NUM_BYTES);
  localparam int ID_BASE = NUM_BYTES - ID_BYTES;
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(NUM_BYTES);
  localparam logic [DATA_W-1:0] ID_TOP = DATA_W'({MAJOR_ID, MINOR_ID});

  logic [DATA_W-1:0] cellBus [NUM_BYTES];
  logic              flagBus [NUM_BYTES];
  logic [IDX_W-1:0]  idx;
  logic              inArray;
  logic [DATA_W-1:0] rdNext;
  logic              lockQ;

  assign idx     = reqAddr[IDX_W-1:0];
  assign inArray = (reqAddr < LOCK_A);

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    localparam logic [DATA_W-1:0] RST_VAL =
      (i == NUM_BYTES - 1) ? ID_TOP :
      (i == NUM_BYTES - 2) ? REV_ID : '0;
    localparam logic RST_FLAG = (i >= ID_BASE);
    logic [DATA_W-1:0] cellQ;
    logic              flagQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cellQ <= RST_VAL;
        flagQ <= RST_FLAG;
      end else if (strobes.wrByte && (reqAddr == ADDR_W'(i))) begin
        cellQ <= reqWdata;
        flagQ <= 1'b1;
      end
    end
    assign cellBus[i] = cellQ;
    assign flagBus[i] = flagQ;
  end

  // byte counts as programmed when flagged or any bit is set
  assign tgtWritten = inArray && (flagBus[idx] || (|cellBus[idx]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lockQ <= 1'b0;
    else if (strobes.setLock) lockQ <= 1'b1;
  end
  assign lockState = lockQ;

  always_comb begin
    if (inArray)                rdNext = cellBus[idx];
    else if (reqAddr == LOCK_A) rdNext = {{(DATA_W-1){1'b0}}, lockQ};
    else                        rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rdData <= '0;
    else if (reqRe) rdData <= rdNext;
  end
endmodule

// File: rtl/otp_once_regs.sv
module otp_once_regs
  import otp_once_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int DATA_W    = 8,
  parameter logic [3:0] MAJOR_ID = 4'h9,
  parameter logic [3:0] MINOR_ID = 4'h1,
  parameter logic [DATA_W-1:0] REV_ID = 8'h23,
  localparam int ADDR_W   = $clog2(NUM_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWe,
  input  logic              reqRe,
  output logic [DATA_W-1:0] rdData,
  output logic              wrErr
);
  localparam int ID_BYTES = 2;

  otpStrobes_t strobes;
  logic        tgtWritten;
  logic        lockState;

  otp_once_ctrl #(
    .NUM_BYTES(NUM_BYTES), .ID_BYTES(ID_BYTES), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .lockBit(reqWdata[0]),
    .reqWe(reqWe), .tgtWritten(tgtWritten), .lockState(lockState),
    .strobes(strobes), .wrErr(wrErr)
  );

  otp_once_dp #(
    .NUM_BYTES(NUM_BYTES), .ID_BYTES(ID_BYTES), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .MAJOR_ID(MAJOR_ID), .MINOR_ID(MINOR_ID), .REV_ID(REV_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqRe(reqRe), .strobes(strobes), .rdData(rdData),
    .tgtWritten(tgtWritten), .lockState(lockState)
  );
endmodule

// File: rtl/otp_once_regs_chk.sv
module otp_once_regs_chk #(
  parameter int NUM_BYTES = 32,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              wdBit0,
  input logic              reqWe,
  input logic              reqRe,
  input logic [DATA_W-1:0] rdData,
  input logic              wrErr,
  input logic              lockState
);
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(NUM_BYTES);

  // R8: lock flag never clears outside reset
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    lockState |=> lockState);

  // R8: any write while locked is refused
  p_locked_refuse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqWe && lockState) |=> wrErr);

  // R6: identifier bytes always refuse writes
  p_id_refuse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqWe && (reqAddr == LOCK_A - 1 || reqAddr == LOCK_A - 2)) |=> wrErr);

  // R9: out-of-range writes refused
  p_oob_refuse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqWe && reqAddr > LOCK_A) |=> wrErr);

  // R10: no error without a write
  p_idle_no_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqWe |=> !wrErr);

  // R2: read data holds without a read request
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqRe |=> $stable(rdData));

  // R7: writing bit 0 high to the lock address sets the flag
  p_lock_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqWe && reqAddr == LOCK_A && wdBit0) |=> lockState);
endmodule

bind otp_once_regs otp_once_regs_chk #(
  .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .wdBit0(reqWdata[0]),
  .reqWe(reqWe), .reqRe(reqRe), .rdData(rdData), .wrErr(wrErr),
  .lockState(lockState)
);

// File: tb/otp_once_regs_tb.sv
`timescale 1ns/1ps
module otp_once_regs_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic       reqWe = 1'b0;
  logic       reqRe = 1'b0;
  logic [7:0] rdData;
  logic       wrErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  otp_once_regs u_dut (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqWe(reqWe), .reqRe(reqRe), .rdData(rdData), .wrErr(wrErr)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqWe = 1'b0; reqRe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // write, sample error after the capturing edge
  task automatic doWrite(input logic [5:0] a, input logic [7:0] d, output logic err);
    @(negedge clk);
    reqAddr = a; reqWdata = d; reqWe = 1'b1; reqRe = 1'b0;
    @(posedge clk); #1;
    err = wrErr;
    reqWe = 1'b0;
  endtask

  task automatic doRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reqAddr = a; reqRe = 1'b1; reqWe = 1'b0;
    @(posedge clk); #1;
    d = rdData;
    reqRe = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "wrErr after reset", int'(wrErr), 0);
    doRead(6'd0, d);  chk("R1", "byte0", d, 8'h00);
    doRead(6'd17, d); chk("R1", "byte17", d, 8'h00);
    doRead(6'd29, d); chk("R1", "byte29", d, 8'h00);
    doRead(6'd30, d); chk("R1", "byte30 revision", d, 8'h23);
    doRead(6'd31, d); chk("R1", "byte31 family", d, 8'h91);
    doRead(6'd32, d); chk("R1", "lock flag", d, 8'h00);
  endtask

  task automatic t_accept();
    logic e; logic [7:0] d;
    doWrite(6'd5, 8'hA5, e); chk("R3", "fresh write err", e, 0);
    doRead(6'd5, d);         chk("R3", "byte5 value", d, 8'hA5);
  endtask

  task automatic t_refuse();
    logic e; logic [7:0] d;
    doWrite(6'd5, 8'h5A, e); chk("R4", "rewrite err", e, 1);
    doRead(6'd5, d);         chk("R4", "byte5 kept", d, 8'hA5);
    doWrite(6'd7, 8'h00, e); chk("R4", "zero write err", e, 0);
    doWrite(6'd7, 8'h01, e); chk("R4", "rewrite after zero err", e, 1);
    doRead(6'd7, d);         chk("R4", "byte7 kept", d, 8'h00);
  endtask

  task automatic t_others();
    logic e; logic [7:0] d;
    doWrite(6'd29, 8'h3C, e); chk("R5", "byte29 write err", e, 0);
    doWrite(6'd0, 8'hFF, e);  chk("R5", "byte0 write err", e, 0);
    doRead(6'd29, d);         chk("R5", "byte29 value", d, 8'h3C);
    doRead(6'd0, d);          chk("R5", "byte0 value", d, 8'hFF);
  endtask

  task automatic t_id();
    logic e; logic [7:0] d;
    doWrite(6'd30, 8'h00, e); chk("R6", "byte30 write err", e, 1);
    doWrite(6'd31, 8'hFF, e); chk("R6", "byte31 write err", e, 1);
    doRead(6'd30, d);         chk("R6", "byte30 kept", d, 8'h23);
    doRead(6'd31, d);         chk("R6", "byte31 kept", d, 8'h91);
  endtask

  task automatic t_oob();
    logic e; logic [7:0] d;
    doWrite(6'd40, 8'h11, e); chk("R9", "addr40 write err", e, 1);
    doRead(6'd40, d);         chk("R9", "addr40 read", d, 8'h00);
    doRead(6'd63, d);         chk("R9", "addr63 read", d, 8'h00);
  endtask

  task automatic t_errpulse();
    logic e;
    doWrite(6'd5, 8'h00, e); chk("R10", "refused err", e, 1);
    @(posedge clk); #1;      chk("R10", "err after one cycle", int'(wrErr), 0);
    doWrite(6'd9, 8'h09, e); chk("R10", "accepted err", e, 0);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    doRead(6'd5, d);         chk("R2", "read byte5", d, 8'hA5);
    @(negedge clk); reqAddr = 6'd29;
    @(posedge clk); #1;      chk("R2", "hold without read", int'(rdData), 8'hA5);
  endtask

  task automatic t_lock();
    logic e; logic [7:0] d;
    doWrite(6'd32, 8'h00, e); chk("R7", "lock bit0 low err", e, 0);
    doRead(6'd32, d);         chk("R7", "lock still clear", d, 8'h00);
    doWrite(6'd32, 8'h01, e); chk("R7", "lock set err", e, 0);
    doRead(6'd32, d);         chk("R7", "lock reads set", d, 8'h01);
  endtask

  task automatic t_locked();
    logic e; logic [7:0] d;
    doWrite(6'd10, 8'h44, e); chk("R8", "locked fresh write err", e, 1);
    doRead(6'd10, d);         chk("R8", "byte10 unchanged", d, 8'h00);
    doWrite(6'd32, 8'h00, e); chk("R8", "locked lock write err", e, 1);
    doRead(6'd32, d);         chk("R8", "lock stays set", d, 8'h01);
    doRead(6'd5, d);          chk("R2", "read while locked", d, 8'hA5);
  endtask

  task automatic t_reset_again();
    logic [7:0] d;
    doReset();
    doRead(6'd32, d); chk("R8", "reset clears lock", d, 8'h00);
    doRead(6'd5, d);  chk("R1", "byte5 after reset", d, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    @(posedge clk); #1;
    t_reset();
    t_accept();
    t_refuse();
    t_others();
    t_id();
    t_oob();
    t_errpulse();
    t_hold();
    t_lock();
    t_locked();
    t_reset_again();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule